// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

The block drives four pulse-width modulated outputs. Each output has its own 256-byte register window on a plain byte-wide write/read bus. A channel counts a 9-bit period of 512 steps. The length of one step comes from three things: the chosen reference tick, a predivider taken from the set {1, 3, 5, 6}, and a power-of-two stage from 2^0 to 2^7. The output is high for the programmed number of steps at the start of each period. The three reference ticks are single-cycle enable strobes that run on the one system clock; the block makes no clocks of its own.

Software writes the clock choice, prescale and duty into staging registers. These registers do not touch the running waveform. Writing the sync bit moves them into the active counter in one step. The move happens at once and restarts the period. When the glitch-removal bit is set, the move instead waits for the next period wrap, so that no period is cut short. Output enable, source select and tristate control act directly, without a sync.

Top module: `pwm_quad`

## Requirements
- R1: Channel n (0 to 3) is addressed with busAddr[9:8] = n and the register offset in busAddr[7:0]. Offset 0x05 reads back the fixed code set by parameter SUBTYPE_CODE (default 0x2B). A write to one channel changes no other channel.
- R2: Offsets 0x41, 0x42, 0x43, 0x44, 0x45 and 0x46 read back the last byte written to them. The sync register at 0x47 always reads 0.
- R3: Bits [1:0] of 0x41 pick the reference tick. Code 1 is tickSlow, 2 is tickMid and 3 is tickFast. With code 0 the counter stops and the output level is low.
- R4: One count step takes P × 2^E reference ticks. E is bits [2:0] of 0x42. P is 1, 3, 5 or 6 for codes 0 to 3 in bits [6:5] of 0x42. A period is 512 steps.
- R5: The 16-bit duty D is 0x45 (high byte) joined to 0x44 (low byte). The output level is high for D steps of each period. D = 0 keeps it low, and D ≥ 512 keeps it high.
- R6: Writes to 0x41, 0x42, 0x44 and 0x45 leave the running waveform unchanged until bit 0 of 0x47 is written as 1.
- R7: If bit 5 of 0x43 is 0 when the sync is written, the staged settings are active from the next cycle and the period restarts at step 0.
- R8: If bit 5 of 0x43 is 1 when the sync is written, the settings are held and applied at the next period wrap, and the current period runs to its end with the old settings.
- R9: pwmOut of a channel follows the counter level only when bit 7 (output enable) and bit 2 (counter source) of 0x46 are both 1. Otherwise it is 0. Bit 1 (ramp source) is stored only.
- R10: pwmOe of a channel is 0 when bit 7 of 0x46 is 0 and bit 5 (tristate) is 1. Otherwise it is 1.
- R11: Each channel keeps its own period and duty while the others run.
- R12: After reset all registers read 0, pwmOut is 0 and pwmOe is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickSlow | input | 1 | Enable strobe for the slow reference (1024 Hz) |
| tickMid | input | 1 | Enable strobe for the middle reference (32768 Hz) |
| tickFast | input | 1 | Enable strobe for the fast reference (19.2 MHz) |
| busWe | input | 1 | Write strobe, one byte per cycle |
| busAddr | input | 10 | Channel in [9:8], register offset in [7:0] |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| pwmOut | output | 4 | Output level per channel |
| pwmOe | output | 4 | Output driver enable per channel; 0 means high-Z |

## Verification
The bench counts high cycles over whole periods with the fast, middle and slow ticks and with odd and even predividers. A prescaler that wraps one tick early or late shows up as a count that is off by a multiple of the step. The duty extremes 0, 512 and 0xFFFF are tested, which catches an off-by-one or a truncated duty compare. A duty written without a sync must leave the high-cycle count unchanged, which exposes registers that were not double-buffered. A sync made partway through a period with glitch removal on must leave the output low right after the write. A design that applied the new settings at once would restart the period and drive the output high there.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int BYTE_W    = 8;
  localparam int EXP_W     = 3;
  localparam int EXPC_W    = (1 << EXP_W) - 1;
  localparam int PERIOD_W  = 9;
  localparam int DUTY_W    = 16;

  localparam logic [7:0] OFF_SUBTYPE  = 8'h05;
  localparam logic [7:0] OFF_SIZE     = 8'h41;
  localparam logic [7:0] OFF_PRESCALE = 8'h42;
  localparam logic [7:0] OFF_TYPE     = 8'h43;
  localparam logic [7:0] OFF_DUTY_LO  = 8'h44;
  localparam logic [7:0] OFF_DUTY_HI  = 8'h45;
  localparam logic [7:0] OFF_ENABLE   = 8'h46;
  localparam logic [7:0] OFF_SYNC     = 8'h47;

  typedef struct packed {
    logic [1:0]        refSel;
    logic [1:0]        divSel;
    logic [EXP_W-1:0]  expSel;
    logic [DUTY_W-1:0] duty;
  } chCfg_t;

  typedef struct packed {
    logic commit;
    logic glitchFree;
  } chStrobe_t;

  // last value of the predivider counter for each code: divide by 1, 3, 5, 6
  function automatic logic [2:0] preMax(input logic [1:0] code);
    case (code)
      2'd0:    preMax = 3'd0;
      2'd1:    preMax = 3'd2;
      2'd2:    preMax = 3'd4;
      default: preMax = 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter logic [7:0] SUBTYPE_CODE = 8'h2B,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int AW = CH_W + 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWe,
  input  logic [AW-1:0]                 busAddr,
  input  logic [BYTE_W-1:0]             busWdata,
  output logic [BYTE_W-1:0]             busRdata,
  output chCfg_t    [NUM_CH-1:0]        stagedCfg,
  output chStrobe_t [NUM_CH-1:0]        strobe,
  output logic      [NUM_CH-1:0]        outEnable,
  output logic      [NUM_CH-1:0]        triState,
  output logic      [NUM_CH-1:0]        srcPwm
);
  logic [CH_W-1:0] chSel;
  logic [7:0]      regOff;
  logic [NUM_CH-1:0][BYTE_W-1:0] sizeReg, preReg, typeReg, dutyLoReg, dutyHiReg, enReg;

  assign chSel  = busAddr[AW-1:8];
  assign regOff = busAddr[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeReg   <= '0;
      preReg    <= '0;
      typeReg   <= '0;
      dutyLoReg <= '0;
      dutyHiReg <= '0;
      enReg     <= '0;
    end else if (busWe) begin
      case (regOff)
        OFF_SIZE:     sizeReg[chSel]   <= busWdata;
        OFF_PRESCALE: preReg[chSel]    <= busWdata;
        OFF_TYPE:     typeReg[chSel]   <= busWdata;
        OFF_DUTY_LO:  dutyLoReg[chSel] <= busWdata;
        OFF_DUTY_HI:  dutyHiReg[chSel] <= busWdata;
        OFF_ENABLE:   enReg[chSel]     <= busWdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regOff)
      OFF_SUBTYPE:  busRdata = SUBTYPE_CODE;
      OFF_SIZE:     busRdata = sizeReg[chSel];
      OFF_PRESCALE: busRdata = preReg[chSel];
      OFF_TYPE:     busRdata = typeReg[chSel];
      OFF_DUTY_LO:  busRdata = dutyLoReg[chSel];
      OFF_DUTY_HI:  busRdata = dutyHiReg[chSel];
      OFF_ENABLE:   busRdata = enReg[chSel];
      default:      busRdata = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign stagedCfg[i].refSel = sizeReg[i][1:0];
    assign stagedCfg[i].divSel = preReg[i][6:5];
    assign stagedCfg[i].expSel = preReg[i][EXP_W-1:0];
    assign stagedCfg[i].duty   = {dutyHiReg[i], dutyLoReg[i]};
    assign strobe[i].commit     = busWe && (chSel == CH_W'(i)) &&
                                  (regOff == OFF_SYNC) && busWdata[0];
    assign strobe[i].glitchFree = typeReg[i][5];
    assign outEnable[i] = enReg[i][7];
    assign triState[i]  = enReg[i][5];
    assign srcPwm[i]    = enReg[i][2];
  end
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickSlow,
  input  logic      tickMid,
  input  logic      tickFast,
  input  chCfg_t    cfgIn,
  input  chStrobe_t strobe,
  output logic      level
);
  localparam logic [PERIOD_W-1:0] LAST_CNT = '1;
  localparam logic [DUTY_W-1:0]   FULL_DUTY = DUTY_W'(1 << PERIOD_W);

  chCfg_t act, pend;
  logic   pendValid;
  logic [2:0]          preCnt, preMaxV;
  logic [EXPC_W-1:0]   expCnt, expMaxV;
  logic [PERIOD_W-1:0] cnt;
  logic tickEn, step, wrap, applyNow;

  always_comb begin
    case (act.refSel)
      2'd1:    tickEn = tickSlow;
      2'd2:    tickEn = tickMid;
      2'd3:    tickEn = tickFast;
      default: tickEn = 1'b0;
    endcase
  end

  assign preMaxV  = preMax(act.divSel);
  assign expMaxV  = ~({EXPC_W{1'b1}} << act.expSel);
  assign step     = tickEn && (preCnt == preMaxV) && (expCnt == expMaxV);
  assign wrap     = step && (cnt == LAST_CNT);
  assign applyNow = strobe.commit && !strobe.glitchFree;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      act       <= '0;
      pend      <= '0;
      pendValid <= 1'b0;
      preCnt    <= '0;
      expCnt    <= '0;
      cnt       <= '0;
    end else if (applyNow) begin
      act       <= cfgIn;
      pendValid <= 1'b0;
      preCnt    <= '0;
      expCnt    <= '0;
      cnt       <= '0;
    end else begin
      if (tickEn) begin
        if (preCnt == preMaxV) begin
          preCnt <= '0;
          if (expCnt == expMaxV) begin
            expCnt <= '0;
            cnt    <= cnt + 1'b1;
          end else begin
            expCnt <= expCnt + 1'b1;
          end
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
      if (wrap && pendValid) act <= pend;
      if (strobe.commit) begin
        pend      <= cfgIn;
        pendValid <= 1'b1;
      end else if (wrap) begin
        pendValid <= 1'b0;
      end
    end
  end

  assign level = (act.refSel != 2'd0) &&
                 ((act.duty >= FULL_DUTY) || (DUTY_W'(cnt) < act.duty));

  // R4
  no_prediv_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preMaxV);

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !applyNow |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 9'd1));

  // R3
  ref_off_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (act.refSel == 2'd0 && !applyNow) |=> $stable(cnt));

  // R8
  deferred_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !wrap && !applyNow) |=> $stable(act));
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter logic [7:0] SUBTYPE_CODE = 8'h2B,
  localparam int AW = $clog2(NUM_CH) + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSlow,
  input  logic              tickMid,
  input  logic              tickFast,
  input  logic              busWe,
  input  logic [AW-1:0]     busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] pwmOe
);
  chCfg_t    [NUM_CH-1:0] stagedCfg;
  chStrobe_t [NUM_CH-1:0] strobe;
  logic      [NUM_CH-1:0] outEnable, triState, srcPwm, level;

  pwm_quad_ctrl #(.NUM_CH(NUM_CH), .SUBTYPE_CODE(SUBTYPE_CODE)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .stagedCfg(stagedCfg),
    .strobe(strobe), .outEnable(outEnable), .triState(triState), .srcPwm(srcPwm)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    pwm_quad_chan i_chan (
      .clk(clk), .rstN(rstN), .tickSlow(tickSlow), .tickMid(tickMid),
      .tickFast(tickFast), .cfgIn(stagedCfg[i]), .strobe(strobe[i]),
      .level(level[i])
    );
    assign pwmOut[i] = outEnable[i] && srcPwm[i] && level[i];
    assign pwmOe[i]  = outEnable[i] || !triState[i];

    // R10
    hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      !pwmOe[i] |-> !pwmOut[i]);
  end
endmodule

// File: tb/test_pwm_quad.sv
module test_pwm_quad;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [9:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [3:0] pwmOut, pwmOe;
  logic [3:0] phase = '0;
  logic tickSlow, tickMid, tickFast;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(negedge clk) phase <= phase + 1'b1;
  assign tickFast = 1'b1;
  assign tickMid  = (phase[1:0] == 2'd0);
  assign tickSlow = (phase == 4'd0);

  pwm_quad i_pwm_quad (
    .clk(clk), .rstN(rstN), .tickSlow(tickSlow), .tickMid(tickMid),
    .tickFast(tickFast), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic wr(input int ch, input logic [7:0] off, input logic [7:0] data);
    @(negedge clk);
    busWe = 1'b1; busAddr = {2'(ch), off}; busWdata = data;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [7:0] off, output int data);
    busAddr = {2'(ch), off};
    #1 data = busRdata;
  endtask

  task automatic setup(input int ch, input logic [7:0] size, input logic [7:0] pre,
                       input int duty);
    wr(ch, 8'h41, size);
    wr(ch, 8'h42, pre);
    wr(ch, 8'h44, 8'(duty));
    wr(ch, 8'h45, 8'(duty >> 8));
    wr(ch, 8'h47, 8'h01);
  endtask

  task automatic countHigh(input int ch, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (pwmOut[ch]) c++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int v;
    chk("R12 pwmOut after reset", int'(pwmOut), 0);
    chk("R12 pwmOe after reset", int'(pwmOe), 15);
    rd(0, 8'h44, v); chk("R12 duty reg after reset", v, 0);
  endtask

  task automatic t_map;
    int v;
    rd(0, 8'h05, v); chk("R1 subtype ch0", v, 8'h2B);
    rd(3, 8'h05, v); chk("R1 subtype ch3", v, 8'h2B);
    wr(2, 8'h44, 8'h5A);
    rd(2, 8'h44, v); chk("R1 write ch2 reads back", v, 8'h5A);
    rd(1, 8'h44, v); chk("R1 ch1 untouched", v, 0);
    wr(2, 8'h44, 8'h00);
  endtask

  task automatic t_readback;
    int v;
    wr(1, 8'h42, 8'h65);
    rd(1, 8'h42, v); chk("R2 prescale readback", v, 8'h65);
    wr(1, 8'h46, 8'h22);
    rd(1, 8'h46, v); chk("R2 enable readback", v, 8'h22);
    wr(1, 8'h47, 8'h01);
    rd(1, 8'h47, v); chk("R2 sync reads zero", v, 0);
    wr(1, 8'h42, 8'h00);
    wr(1, 8'h46, 8'h00);
  endtask

  task automatic t_basic;
    int c;
    wr(0, 8'h46, 8'h84);
    setup(0, 8'h03, 8'h00, 100);
    chk("R7 period restarts high after sync", int'(pwmOut[0]), 1);
    countHigh(0, 512, c); chk("R5 duty 100 high cycles", c, 100);
  endtask

  task automatic t_staged;
    int c;
    wr(0, 8'h44, 8'(300)); wr(0, 8'h45, 8'(300 >> 8));
    wr(0, 8'h42, 8'h21);
    countHigh(0, 512, c); chk("R6 staged duty has no effect", c, 100);
    wr(0, 8'h42, 8'h00);
    wr(0, 8'h47, 8'h01);
    countHigh(0, 512, c); chk("R6 duty applied after sync", c, 300);
  endtask

  task automatic t_extremes;
    int c;
    setup(0, 8'h03, 8'h00, 0);
    countHigh(0, 512, c); chk("R5 duty 0 stays low", c, 0);
    setup(0, 8'h03, 8'h00, 512);
    countHigh(0, 512, c); chk("R5 duty 512 stays high", c, 512);
    setup(0, 8'h03, 8'h00, 16'hFFFF);
    countHigh(0, 512, c); chk("R5 duty 0xFFFF stays high", c, 512);
  endtask

  task automatic t_prescale;
    int c;
    setup(0, 8'h03, 8'h21, 10);
    countHigh(0, 3072, c); chk("R4 div3 exp1 high cycles", c, 60);
    setup(0, 8'h03, 8'h60, 8);
    countHigh(0, 3072, c); chk("R4 div6 exp0 high cycles", c, 48);
    setup(0, 8'h03, 8'h42, 3);
    countHigh(0, 10240, c); chk("R4 div5 exp2 high cycles", c, 60);
  endtask

  task automatic t_refsel;
    int c;
    setup(0, 8'h02, 8'h00, 50);
    countHigh(0, 2048, c); chk("R3 mid tick high cycles", c, 200);
    setup(0, 8'h01, 8'h00, 4);
    countHigh(0, 8192, c); chk("R3 slow tick high cycles", c, 64);
    setup(0, 8'h00, 8'h00, 50);
    countHigh(0, 600, c); chk("R3 reference off stays low", c, 0);
  endtask

  task automatic t_glitch;
    int c;
    setup(0, 8'h03, 8'h00, 100);
    repeat (200) @(negedge clk);
    wr(0, 8'h43, 8'h20);
    wr(0, 8'h44, 8'(300)); wr(0, 8'h45, 8'(300 >> 8));
    wr(0, 8'h47, 8'h01);
    chk("R8 no restart on deferred sync", int'(pwmOut[0]), 0);
    repeat (512) @(negedge clk);
    countHigh(0, 512, c); chk("R8 deferred duty after wrap", c, 300);
    wr(0, 8'h43, 8'h00);
  endtask

  task automatic t_enable;
    int c;
    setup(0, 8'h03, 8'h00, 200);
    wr(0, 8'h46, 8'h04);
    countHigh(0, 512, c); chk("R9 output enable clear gives 0", c, 0);
    chk("R10 oe high without tristate", int'(pwmOe[0]), 1);
    wr(0, 8'h46, 8'h24);
    chk("R10 oe low when disabled and tristate", int'(pwmOe[0]), 0);
    wr(0, 8'h46, 8'h80);
    countHigh(0, 512, c); chk("R9 no counter source gives 0", c, 0);
    wr(0, 8'h46, 8'hA4);
    chk("R10 oe high when enabled with tristate", int'(pwmOe[0]), 1);
    countHigh(0, 512, c); chk("R9 enabled follows duty", c, 200);
  endtask

  task automatic t_indep;
    int c0, c1;
    wr(1, 8'h46, 8'h84);
    setup(1, 8'h03, 8'h00, 37);
    setup(0, 8'h03, 8'h00, 100);
    c0 = 0; c1 = 0;
    for (int i = 0; i < 512; i++) begin
      if (pwmOut[0]) c0++;
      if (pwmOut[1]) c1++;
      @(negedge clk);
    end
    chk("R11 ch0 keeps its duty", c0, 100);
    chk("R11 ch1 keeps its duty", c1, 37);
    chk("R11 idle channels stay low", int'(pwmOut[3:2]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_map;
    t_readback;
    t_basic;
    t_staged;
    t_extremes;
    t_prescale;
    t_refsel;
    t_glitch;
    t_enable;
    t_indep;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule